// File: doc/BRIEF.md
# Register-Mapped SPI Master with Byte FIFOs

This block is a byte-oriented SPI master that a processor drives through three 32-bit registers on a simple read/write strobe bus. The first register holds configuration and status. The second is a data port: a write queues a byte for transmission and a read takes the oldest received byte. The third register sets the serial clock divider. Two 16-entry FIFOs sit between the bus and a single shift engine. Every byte shifted out brings one byte back in. Software keeps the transmit queue filled and empties the receive queue, and one interrupt line tells it when to act.

The flow control is designed around that interrupt. A receive-watermark flag rises once 12 bytes are waiting. A completion flag is raised whenever the transfer-active bit is on, nothing is queued and the shifter is idle. Because of this, turning the block on with an empty queue raises completion at once, which acts as a "fill me" request. A chip-select line stays asserted for as long as the active bit is held, across any number of refills. It is not toggled per byte.

Top module: `spim_ctrl`

## Requirements
- R1: After reset, the control word reads 0x0004_0000 (only "TX can accept" set), the divider reads 0, all three chip-select outputs are high, SCLK is 0 and the interrupt is low.
- R2: The control word is decoded as follows.
  - Address 0x0 is the control word, 0x4 is the data port and 0x8 is the divider.
  - Control bits: [1:0] select line, 2 CPHA, 3 CPOL, 4 flush TX, 5 flush RX, 6 common active-high select, 7 active, 9 done interrupt enable, 10 watermark interrupt enable, [23:21] per-line active-high select.
  - Status bits: 16 done, 17 RX non-empty, 18 TX not full, 19 RX watermark, 20 RX full.
- R3: Each byte is sent MSB first on MOSI. The byte received from MISO is pushed into the RX FIFO, and bytes are returned in the order they were sent.
- R4: SCLK rests at the CPOL level and makes exactly 16 edges per byte. MISO is sampled on the first edge of each bit when CPHA=0 and on the second edge when CPHA=1.
- R5: Each SCLK half-period lasts divider/2 system clocks. A divider of 0 acts as 65536, so the half-period is 32768 clocks.
- R6: Done reads 1 exactly when the active bit is 1, the TX FIFO is empty and no byte is shifting. Setting the active bit with an empty TX FIFO raises done immediately.
- R7: RX watermark reads 1 when 12 or more bytes are held. RX full reads 1 at 16 bytes.
- R8: The interrupt equals (done AND its enable) OR (watermark AND its enable).
- R9: While the active bit is set, the line chosen by bits [1:0] drives its active level and every other line drives its inactive level. A line is active-high if bit 6 or its own bit in [23:21] is set, and active-low otherwise. Clearing the active bit drives all lines inactive.
- R10: Writing 1 to a flush bit empties that FIFO in the same write, and a flushed TX byte is never shifted. Both flush bits always read back 0.
- R11: When the RX FIFO is full, no new byte starts and SCLK stays idle until a byte is popped, so nothing is lost. Reading an empty RX FIFO returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous-free synchronous reset |
| reg_addr | input | 4 | Byte address of the register access |
| reg_wr | input | 1 | Write strobe, one cycle per access |
| reg_rd | input | 1 | Read strobe; pops the RX FIFO when addressing the data port |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the same cycle as the address |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_line | output | 3 | Chip-select lines with programmable polarity |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach is a full receive queue with one more byte still queued for transmission. In that state the shifter must hold SCLK quiet until a pop. Reaching it takes sixteen back-to-back bytes that are never read, followed by a seventeenth write. The bench then counts SCLK edges across a long idle window, pops a single byte and expects exactly one more byte time of edges. MISO is looped back from MOSI through a bench-controlled inverter, so each received byte is known in advance. A bench model of a slave also captures MOSI on the mode's sampling edge to confirm bit order.

// File: rtl/spim_pkg.sv
`timescale 1ns/1ps
package spim_pkg;
    localparam int BUS_W  = 32;
    localparam int BYTE_W = 8;
    localparam int NUM_CS = 3;

    // control/status bit positions (software decodes these)
    localparam int B_CPHA    = 2;
    localparam int B_CPOL    = 3;
    localparam int B_CLR_TX  = 4;
    localparam int B_CLR_RX  = 5;
    localparam int B_CSPOL   = 6;
    localparam int B_TA      = 7;
    localparam int B_IE_DONE = 9;
    localparam int B_IE_RXR  = 10;
    localparam int B_DONE    = 16;
    localparam int B_RXD     = 17;
    localparam int B_TXD     = 18;
    localparam int B_RXR     = 19;
    localparam int B_RXF     = 20;
    localparam int B_LPOL    = 21;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_DATA = 2'd1,
        SEL_DIV  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [NUM_CS-1:0] line_pol;
        logic              ie_rxr;
        logic              ie_done;
        logic              ta;
        logic              cs_pol;
        logic              cpol;
        logic              cpha;
        logic [1:0]        cs_num;
    } ctrl_t;
endpackage

// File: rtl/spim_fifo.sv
`timescale 1ns/1ps
module spim_fifo #(
    parameter  int DEPTH = 16,
    parameter  int W     = 8,
    localparam int PW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic [CW-1:0] count,
    output logic          full
);
    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_t;

    fifo_t      q, d;
    logic       do_push, do_pop;
    logic [W-1:0] mem_q [DEPTH];

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_comb begin
        do_push = push && (q.cnt != CW'(DEPTH)) && !flush;
        do_pop  = pop && (q.cnt != '0) && !flush;
        d = q;
        if (flush) begin
            d = '0;
        end else begin
            if (do_push) d.wp = bump(q.wp);
            if (do_pop)  d.rp = bump(q.rp);
            d.cnt = q.cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[q.wp] <= wdata;
    end

    assign rdata = (q.cnt == '0) ? '0 : mem_q[q.rp];
    assign count = q.cnt;
    assign full  = (q.cnt == CW'(DEPTH));

    AST_FIFO_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n) flush |=> (count == '0)); // R10
    AST_FIFO_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n) (pop && !push && !flush && count != '0) |=> (count == $past(count) - CW'(1))); // R11
endmodule

// File: rtl/spim_shifter.sv
`timescale 1ns/1ps
module spim_shifter #(
    parameter int DIV_W = 16,
    parameter int W     = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpol,
    input  logic             cpha,
    input  logic [DIV_W-1:0] div,
    input  logic             start,
    input  logic [W-1:0]     tx_byte,
    input  logic             miso,
    output logic             sclk,
    output logic             mosi,
    output logic             busy,
    output logic             rx_push,
    output logic [W-1:0]     rx_byte
);
    localparam int EDGES = 2 * W;
    localparam int EW    = $clog2(EDGES);
    localparam logic [EW-1:0]    LAST_EDGE = EW'(EDGES - 1);
    localparam logic [DIV_W-1:0] SLOW_HALF = {1'b0, {(DIV_W-1){1'b1}}};

    typedef struct packed {
        logic             busy;
        logic             sclk;
        logic [DIV_W-1:0] cnt;
        logic [EW-1:0]    edge_n;
        logic [W-1:0]     tx_sr;
        logic [W-1:0]     rx_sr;
    } sh_t;

    sh_t              q, d;
    logic [DIV_W-1:0] half_m1;
    logic             lead, sample;

    always_comb begin
        // half period minus one, in system clocks
        if (div == '0)                half_m1 = SLOW_HALF;
        else if (div < DIV_W'(2))     half_m1 = '0;
        else                          half_m1 = (div >> 1) - DIV_W'(1);

        d       = q;
        rx_push = 1'b0;
        rx_byte = q.rx_sr;
        lead    = !q.edge_n[0];
        sample  = lead ^ cpha;

        if (!q.busy) begin
            d.sclk = cpol;
            if (start) begin
                d.busy   = 1'b1;
                d.cnt    = half_m1;
                d.edge_n = '0;
                d.tx_sr  = tx_byte;
                d.rx_sr  = '0;
            end
        end else if (q.cnt != '0) begin
            d.cnt = q.cnt - DIV_W'(1);
        end else begin
            d.sclk   = ~q.sclk;
            d.cnt    = half_m1;
            d.edge_n = q.edge_n + EW'(1);
            if (sample)
                d.rx_sr = {q.rx_sr[W-2:0], miso};
            else if (q.edge_n != '0)
                d.tx_sr = {q.tx_sr[W-2:0], 1'b0};
            if (q.edge_n == LAST_EDGE) begin
                d.busy  = 1'b0;
                rx_push = 1'b1;
                rx_byte = d.rx_sr;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sclk = q.sclk;
    assign mosi = q.tx_sr[W-1];
    assign busy = q.busy;

    AST_SCLK_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n) (!q.busy && $past(!q.busy) && $stable(cpol)) |-> (sclk == cpol)); // R4
endmodule

// File: rtl/spim_ctrl.sv
`timescale 1ns/1ps
module spim_ctrl
    import spim_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int RX_MARK    = 12,
    parameter int DIV_W      = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  reg_addr,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        sclk,
    output logic        mosi,
    input  logic        miso,
    output logic [2:0]  cs_line,
    output logic        irq
);
    localparam int CW = $clog2(FIFO_DEPTH + 1);

    typedef struct packed {
        ctrl_t            ctrl;
        logic [DIV_W-1:0] div;
    } regs_t;

    regs_t          q, d;
    reg_sel_e       sel;
    logic           wr_ctrl, wr_data, wr_div, rd_data;
    logic           flush_tx, flush_rx;
    logic           start;
    logic [CW-1:0]  tx_count, rx_count;
    logic           tx_full, rx_full, tx_empty, rx_empty;
    logic [BYTE_W-1:0] tx_head, rx_head;
    logic           sh_busy, sh_rx_push;
    logic [BYTE_W-1:0] sh_rx_byte;
    logic           done, rxr;
    logic [BUS_W-1:0] stat;
    logic [NUM_CS-1:0] act_lvl;
    logic           unused_bits;

    assign unused_bits = ^{reg_wdata[31:24], reg_wdata[20:16], reg_addr[1:0]};

    // ---- bus decode and register next state
    always_comb begin
        sel      = reg_sel_e'(reg_addr[3:2]);
        wr_ctrl  = reg_wr && (sel == SEL_CTRL);
        wr_data  = reg_wr && (sel == SEL_DATA);
        wr_div   = reg_wr && (sel == SEL_DIV);
        rd_data  = reg_rd && (sel == SEL_DATA);
        flush_tx = wr_ctrl && reg_wdata[B_CLR_TX];
        flush_rx = wr_ctrl && reg_wdata[B_CLR_RX];

        d = q;
        if (wr_ctrl) begin
            d.ctrl.cs_num   = reg_wdata[1:0];
            d.ctrl.cpha     = reg_wdata[B_CPHA];
            d.ctrl.cpol     = reg_wdata[B_CPOL];
            d.ctrl.cs_pol   = reg_wdata[B_CSPOL];
            d.ctrl.ta       = reg_wdata[B_TA];
            d.ctrl.ie_done  = reg_wdata[B_IE_DONE];
            d.ctrl.ie_rxr   = reg_wdata[B_IE_RXR];
            d.ctrl.line_pol = reg_wdata[B_LPOL +: NUM_CS];
        end
        if (wr_div) d.div = reg_wdata[DIV_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // ---- queues
    spim_fifo #(.DEPTH(FIFO_DEPTH), .W(BYTE_W)) u_tx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush_tx),
        .push  (wr_data),
        .wdata (reg_wdata[BYTE_W-1:0]),
        .pop   (start),
        .rdata (tx_head),
        .count (tx_count),
        .full  (tx_full)
    );

    spim_fifo #(.DEPTH(FIFO_DEPTH), .W(BYTE_W)) u_rx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush_rx),
        .push  (sh_rx_push),
        .wdata (sh_rx_byte),
        .pop   (rd_data),
        .rdata (rx_head),
        .count (rx_count),
        .full  (rx_full)
    );

    assign tx_empty = (tx_count == '0);
    assign rx_empty = (rx_count == '0);

    // a byte leaves only while active, with room reserved in the RX queue
    assign start = q.ctrl.ta && !tx_empty && !rx_full && !sh_busy && !flush_tx;

    spim_shifter #(.DIV_W(DIV_W), .W(BYTE_W)) u_shifter (
        .clk     (clk),
        .rst_n   (rst_n),
        .cpol    (q.ctrl.cpol),
        .cpha    (q.ctrl.cpha),
        .div     (q.div),
        .start   (start),
        .tx_byte (tx_head),
        .miso    (miso),
        .sclk    (sclk),
        .mosi    (mosi),
        .busy    (sh_busy),
        .rx_push (sh_rx_push),
        .rx_byte (sh_rx_byte)
    );

    // ---- status, interrupt, readout
    assign done = q.ctrl.ta && tx_empty && !sh_busy;
    assign rxr  = (rx_count >= CW'(RX_MARK));
    assign irq  = (q.ctrl.ie_done && done) || (q.ctrl.ie_rxr && rxr);

    always_comb begin
        stat                      = '0;
        stat[1:0]                 = q.ctrl.cs_num;
        stat[B_CPHA]              = q.ctrl.cpha;
        stat[B_CPOL]              = q.ctrl.cpol;
        stat[B_CSPOL]             = q.ctrl.cs_pol;
        stat[B_TA]                = q.ctrl.ta;
        stat[B_IE_DONE]           = q.ctrl.ie_done;
        stat[B_IE_RXR]            = q.ctrl.ie_rxr;
        stat[B_DONE]              = done;
        stat[B_RXD]               = !rx_empty;
        stat[B_TXD]               = !tx_full;
        stat[B_RXR]               = rxr;
        stat[B_RXF]               = rx_full;
        stat[B_LPOL +: NUM_CS]    = q.ctrl.line_pol;

        case (sel)
            SEL_CTRL: reg_rdata = stat;
            SEL_DATA: reg_rdata = {{(BUS_W-BYTE_W){1'b0}}, rx_head};
            SEL_DIV:  reg_rdata = {{(BUS_W-DIV_W){1'b0}}, q.div};
            default:  reg_rdata = '0;
        endcase
    end

    // ---- chip selects
    for (genvar gi = 0; gi < NUM_CS; gi++) begin : g_cs
        assign act_lvl[gi] = q.ctrl.cs_pol || q.ctrl.line_pol[gi];
        assign cs_line[gi] = (q.ctrl.ta && (q.ctrl.cs_num == 2'(gi))) ? act_lvl[gi] : ~act_lvl[gi];
    end

    AST_RX_NEVER_DROPS: assert property (@(posedge clk) disable iff (!rst_n) sh_rx_push |-> !rx_full); // R11
    AST_DONE_NO_START: assert property (@(posedge clk) disable iff (!rst_n) (done && !wr_data) |=> !sh_busy); // R6
    AST_CS_AT_MOST_ONE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(~(cs_line ^ act_lvl))); // R9
    AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n) irq |-> (done || rxr)); // R8
endmodule

// File: tb/test_spim_ctrl.sv
`timescale 1ns/1ps
module test_spim_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        sclk, mosi, miso, irq;
    logic [2:0]  cs_line;
    logic        inv = 1'b0;

    always #5 clk = ~clk;
    assign miso = mosi ^ inv;

    spim_ctrl i_spim_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sclk(sclk), .mosi(mosi),
        .miso(miso), .cs_line(cs_line), .irq(irq)
    );

    int n_chk = 0;
    int n_bad = 0;

    // slave model: counts edges, captures MOSI on the sampling edge
    logic tb_cpol = 1'b0;
    logic tb_cpha = 1'b0;
    logic [7:0] cap = '0;
    int   nedge = 0;
    int   mark = 0;
    time  t_mark = 0;
    time  t_last = 0;
    always @(sclk) begin
        if (nedge == mark) t_mark = $time;
        t_last = $time;
        nedge++;
        if ((sclk != tb_cpol) != tb_cpha) cap = {cap[6:0], mosi};
    end

    typedef struct packed {
        logic        cpol;
        logic        cpha;
        logic [15:0] div;
        logic [7:0]  tx;
        logic        inv;
        logic [7:0]  exp_rx;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{1'b0, 1'b0, 16'd2,  8'hA5, 1'b0, 8'hA5},
        '{1'b0, 1'b1, 16'd4,  8'h3C, 1'b1, 8'hC3},
        '{1'b1, 1'b0, 16'd8,  8'h81, 1'b0, 8'h81},
        '{1'b1, 1'b1, 16'd2,  8'h7E, 1'b1, 8'h81},
        '{1'b0, 1'b0, 16'd16, 8'h01, 1'b1, 8'hFE},
        '{1'b1, 1'b1, 16'd4,  8'hC8, 1'b0, 8'hC8}
    };

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
        @(posedge clk);
        #1 reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 v = reg_rdata;
        @(posedge clk);
        #1 reg_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic wait_done(input string tag);
        logic [31:0] s;
        bit got = 1'b0;
        for (int i = 0; i < 3000 && !got; i++) begin
            rd(4'h0, s);
            got = s[16];
        end
        chk(got, tag, 32'(got), 32'd1);
    endtask

    function automatic logic [31:0] cw(input logic [1:0] cs, input bit cpha, input bit cpol,
                                      input bit cspol, input bit ta, input bit ied, input bit ier,
                                      input logic [2:0] lpol, input bit clrtx, input bit clrrx);
        logic [31:0] w = '0;
        w[1:0] = cs; w[2] = cpha; w[3] = cpol; w[4] = clrtx; w[5] = clrrx;
        w[6] = cspol; w[7] = ta; w[9] = ied; w[10] = ier; w[23:21] = lpol;
        return w;
    endfunction

    function automatic logic [7:0] pat(input int i);
        return 8'(i * 17 + 3);
    endfunction

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R6 watchdog actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] s;
        int base;
        idle(5);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        rd(4'h0, s);  chk(s == 32'h0004_0000, "R1 reset status", s, 32'h0004_0000);
        rd(4'h8, s);  chk(s == 32'h0, "R1 reset divider", s, 32'h0);
        chk(cs_line == 3'b111 && sclk == 1'b0 && irq == 1'b0, "R1 reset pins",
            {cs_line, sclk, irq}, {3'b111, 1'b0, 1'b0});
        rd(4'h4, s);  chk(s == 32'h0, "R11 pop of empty RX", s, 32'h0);

        // R6 / R2: enabling with empty TX raises done at once
        wr(4'h0, cw(2'd0, 0, 0, 0, 1, 0, 0, 3'b000, 0, 0));
        rd(4'h0, s);  chk(s == 32'h0005_0080, "R6 R2 done on enable", s, 32'h0005_0080);

        // table walk: four modes, several dividers, loopback with optional inversion
        foreach (VECS[k]) begin
            tb_cpol = VECS[k].cpol;
            tb_cpha = VECS[k].cpha;
            wr(4'h0, cw(2'd0, VECS[k].cpha, VECS[k].cpol, 0, 1, 0, 0, 3'b000, 0, 0));
            wr(4'h8, {16'h0, VECS[k].div});
            idle(3);
            inv  = VECS[k].inv;
            base = nedge;
            mark = base;
            wr(4'h4, {24'h0, VECS[k].tx});
            wait_done("R6 done after byte");
            idle(2);
            chk(nedge - base == 16, "R4 edges per byte", 32'(nedge - base), 32'd16);
            chk(sclk == VECS[k].cpol, "R4 idle level", {31'h0, sclk}, {31'h0, VECS[k].cpol});
            chk(cap == VECS[k].tx, "R3 MOSI MSB first", {24'h0, cap}, {24'h0, VECS[k].tx});
            chk(32'(t_last - t_mark) == 32'(15 * (VECS[k].div / 2) * 10), "R5 edge spacing",
                32'(t_last - t_mark), 32'(15 * (VECS[k].div / 2) * 10));
            chk(cs_line[0] == 1'b0, "R9 select held while active", {29'h0, cs_line}, 32'h6);
            rd(4'h4, s);
            chk(s == {24'h0, VECS[k].exp_rx}, "R3 received byte", s, {24'h0, VECS[k].exp_rx});
        end
        inv = 1'b0;

        // R7 R8 R11: watermark, full, stall on full
        tb_cpol = 1'b0; tb_cpha = 1'b0;
        wr(4'h0, cw(2'd0, 0, 0, 0, 1, 0, 1, 3'b000, 0, 0));
        wr(4'h8, 32'd2);
        for (int i = 0; i < 12; i++) wr(4'h4, {24'h0, pat(i)});
        wait_done("R6 done after 12");
        rd(4'h0, s);  chk(s == 32'h000F_0480, "R7 watermark at 12", s, 32'h000F_0480);
        chk(irq == 1'b1, "R8 watermark interrupt", {31'h0, irq}, 32'h1);
        for (int i = 12; i < 16; i++) wr(4'h4, {24'h0, pat(i)});
        wait_done("R6 done after 16");
        rd(4'h0, s);  chk(s == 32'h001F_0480, "R7 full at 16", s, 32'h001F_0480);
        base = nedge;
        wr(4'h4, 32'hA5);
        idle(200);
        chk(nedge == base, "R11 SCLK idle while RX full", 32'(nedge - base), 32'd0);
        rd(4'h0, s);  chk(s == 32'h001E_0480, "R11 stalled status", s, 32'h001E_0480);
        rd(4'h4, s);  chk(s == {24'h0, pat(0)}, "R11 first popped", s, {24'h0, pat(0)});
        wait_done("R11 resumes after pop");
        chk(nedge - base == 16, "R11 one byte after pop", 32'(nedge - base), 32'd16);
        for (int i = 1; i < 17; i++) begin
            logic [7:0] e;
            e = (i == 16) ? 8'hA5 : pat(i);
            rd(4'h4, s);
            chk(s == {24'h0, e}, "R3 R11 order kept", s, {24'h0, e});
        end
        rd(4'h4, s);  chk(s == 32'h0, "R11 empty pop gives 0", s, 32'h0);
        rd(4'h0, s);  chk(s == 32'h0005_0480, "R7 flags drop after drain", s, 32'h0005_0480);
        chk(irq == 1'b0, "R8 no watermark interrupt", {31'h0, irq}, 32'h0);

        // R8 done interrupt
        wr(4'h0, cw(2'd0, 0, 0, 0, 1, 1, 0, 3'b000, 0, 0));
        idle(2);
        chk(irq == 1'b1, "R8 done interrupt", {31'h0, irq}, 32'h1);
        wr(4'h0, cw(2'd0, 0, 0, 0, 1, 0, 0, 3'b000, 0, 0));
        idle(2);
        chk(irq == 1'b0, "R8 done masked", {31'h0, irq}, 32'h0);

        // R9 chip-select polarity
        wr(4'h0, cw(2'd0, 0, 0, 0, 1, 0, 0, 3'b100, 0, 0));
        idle(1);
        chk(cs_line == 3'b010, "R9 per-line polarity active", {29'h0, cs_line}, 32'h2);
        wr(4'h0, cw(2'd0, 0, 0, 0, 0, 0, 0, 3'b100, 0, 0));
        idle(1);
        chk(cs_line == 3'b011, "R9 per-line polarity released", {29'h0, cs_line}, 32'h3);
        wr(4'h0, cw(2'd1, 0, 0, 1, 1, 0, 0, 3'b000, 0, 0));
        idle(1);
        chk(cs_line == 3'b010, "R9 common high active", {29'h0, cs_line}, 32'h2);
        wr(4'h0, cw(2'd1, 0, 0, 1, 0, 0, 0, 3'b000, 0, 0));
        idle(1);
        chk(cs_line == 3'b000, "R9 common high released", {29'h0, cs_line}, 32'h0);

        // R10 flushes
        wr(4'h0, cw(2'd0, 0, 0, 0, 1, 0, 0, 3'b000, 0, 0));
        wr(4'h4, 32'h11);
        wr(4'h4, 32'h22);
        wait_done("R6 done before flush");
        rd(4'h0, s);  chk(s == 32'h0007_0080, "R10 RX holds data", s, 32'h0007_0080);
        wr(4'h0, cw(2'd0, 0, 0, 0, 0, 0, 0, 3'b000, 0, 1));
        rd(4'h0, s);  chk(s == 32'h0004_0000, "R10 RX flushed, bits read 0", s, 32'h0004_0000);
        wr(4'h4, 32'h33);
        wr(4'h4, 32'h44);
        rd(4'h0, s);  chk(s == 32'h0004_0000, "R6 no done while inactive", s, 32'h0004_0000);
        base = nedge;
        wr(4'h0, cw(2'd0, 0, 0, 0, 1, 0, 0, 3'b000, 1, 0));
        idle(20);
        rd(4'h0, s);  chk(s == 32'h0005_0080, "R10 TX flushed on enable", s, 32'h0005_0080);
        chk(nedge == base, "R10 flushed bytes not sent", 32'(nedge - base), 32'd0);

        // R5 divider 0 means 65536
        wr(4'h8, 32'd0);
        idle(3);
        base = nedge;
        mark = base;
        wr(4'h4, 32'h5A);
        for (int i = 0; i < 70000 && (nedge - base) < 2; i++) @(posedge clk);
        chk(32'(t_last - t_mark) == 32'd327680, "R5 divider zero half period",
            32'(t_last - t_mark), 32'd327680);

        // abort the slow byte with reset and recheck R1
        @(negedge clk) rst_n = 1'b0;
        idle(3);
        @(negedge clk) rst_n = 1'b1;
        rd(4'h0, s);  chk(s == 32'h0004_0000, "R1 status after second reset", s, 32'h0004_0000);
        chk(cs_line == 3'b111, "R1 selects after second reset", {29'h0, cs_line}, 32'h7);

        summary();
        $finish;
    end
endmodule